// File: doc/BRIEF.md
# Palette Overlay Blender

This block lays a palette colour over a 4:4:4 YCbCr pixel stream, one pixel at a time. Each pixel carries a 3-bit overlay select and a 2-bit external blend level. A select of zero means "no overlay here". Codes one to seven pick an entry from a fixed table of seven colour-bar colours. A static 2-bit mode input chooses how the overlay colour and the pixel are combined. The four choices are: off, externally weighted, internally cross-faded, and a hard switch.

In the cross-faded mode, the block softens every change of the select. It does this with a two-step blend of 1/8 and 7/8. The blend begins one pixel before the change, so the block must see the next pixel's select before it can emit the current pixel. For that reason every mode holds exactly one pixel inside the block. The output for pixel n comes out in the cycle after pixel n+1 is accepted. All blends are computed per component as (A*w + B*(8-w) + 4) >> 3, where w is a weight from 0 to 8.

Top module: `ovl_mixer`

## Requirements
- R1: While reset is asserted, and after it is released until the first output, `out_valid_o` is 0 and all three output components are 0.
- R2: Each output pixel is the result for the pixel accepted before the most recently accepted one. `out_valid_o` is 1 only in the cycle after an accepted pixel, and only when an earlier pixel is held. Cycles with `in_valid_i` low produce no output and do not change the held pixel or the select history.
- R3: Mode 2'b00 (off): the output is the pixel unchanged, whatever the select and level inputs are.
- R4: In mode 2'b01 (external) and mode 2'b11 (hard switch), a pixel whose select is 0 passes unchanged. In mode 2'b01 its level is ignored.
- R5: Palette entries as (Y,Cb,Cr) at 8 bits: 1=(180,128,128), 2=(162,44,142), 3=(131,156,44), 4=(112,72,58), 5=(84,184,198), 6=(65,100,212), 7=(35,212,114). For wider pixels the values are shifted left by PIX_W-8.
- R6: Mode 2'b01 with a nonzero select: level 0,1,2,3 gives overlay weight w = 0,1,7,8 eighths. Each component is (ovl*w + pix*(8-w) + 4) >> 3.
- R7: Mode 2'b11 with a nonzero select: the output is the palette colour, and the level is ignored.
- R8: Mode 2'b10 (cross-fade), select moving from 0 to a colour: the pixel before the change blends the new colour at weight 1. The first overlay pixel uses weight 7. Later overlay pixels are the pure colour.
- R9: Mode 2'b10, select moving from a colour to 0: the last overlay pixel is the colour at weight 7 over the pixel. The next pixel uses colour weight 1. After that the pixel passes unchanged.
- R10: Mode 2'b10, select moving from colour P to colour Q: the pixel before the change is Q at weight 1 over P. The aligned pixel is Q at weight 7 over P. After that it is Q alone.
- R11: Mode 2'b10 with no change on either side (previous, current and next select equal) gives the pure colour, or the unchanged pixel for select 0. The select before the first pixel after reset counts as 0.
- R12: Mode 2'b10, when a run is shorter than three pixels and a pixel borders changes on both sides, the blend toward the next select (weight 1) takes precedence over the fade from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Blend mode: 00 off, 01 external, 10 cross-fade, 11 hard switch |
| in_valid_i | input | 1 | Input pixel present this cycle |
| pix_y_i | input | PIX_W | Input luma |
| pix_cb_i | input | PIX_W | Input blue difference |
| pix_cr_i | input | PIX_W | Input red difference |
| ovl_sel_i | input | 3 | Overlay palette select, 0 = none |
| mix_lvl_i | input | 2 | External blend level |
| out_valid_o | output | 1 | Output pixel present this cycle |
| out_y_o | output | PIX_W | Output luma |
| out_cb_o | output | PIX_W | Output blue difference |
| out_cr_o | output | PIX_W | Output red difference |

## Verification
The checker assumes that `mode_i` is held constant while reset is deasserted, because its pass-through properties read the current mode against a pixel that was accepted earlier. The cross-fade results are checked only for runs of at least three pixels, with one deliberate exception that exercises the shorter-run precedence rule. The stimulus changes mode only while reset is held, and each scenario starts from a fresh reset so that the select history begins at zero. Idle gaps are inserted between pixels in one cross-fade scenario, to show that the lookahead pairs only accepted pixels.

// File: rtl/ovl_mix_pkg.sv
package ovl_mix_pkg;

   localparam int SEL_W  = 3;
   localparam int LVL_W  = 2;
   localparam int WGT_W  = 4;
   localparam int NCOMP  = 3;
   localparam int BASE_W = 8;

   typedef enum logic [1:0] {
      MIX_OFF  = 2'b00,
      MIX_EXT  = 2'b01,
      MIX_FADE = 2'b10,
      MIX_HARD = 2'b11
   } mix_mode_e;

   // component order inside a packed triple: [0]=Y, [1]=Cb, [2]=Cr
   function automatic logic [NCOMP-1:0][BASE_W-1:0] pal_base(input logic [SEL_W-1:0] code);
      logic [NCOMP-1:0][BASE_W-1:0] r;
      case (code)
         3'd1:    r = {8'd128, 8'd128, 8'd180};
         3'd2:    r = {8'd142, 8'd44,  8'd162};
         3'd3:    r = {8'd44,  8'd156, 8'd131};
         3'd4:    r = {8'd58,  8'd72,  8'd112};
         3'd5:    r = {8'd198, 8'd184, 8'd84};
         3'd6:    r = {8'd212, 8'd100, 8'd65};
         3'd7:    r = {8'd114, 8'd212, 8'd35};
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic logic [WGT_W-1:0] ext_weight(input logic [LVL_W-1:0] lvl);
      case (lvl)
         2'd0:    return 4'd0;
         2'd1:    return 4'd1;
         2'd2:    return 4'd7;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/ovl_palette.sv
module ovl_palette #(
   parameter int PIX_W = 8
) (
   input  logic [ovl_mix_pkg::SEL_W-1:0]                code_i,
   output logic [ovl_mix_pkg::NCOMP-1:0][PIX_W-1:0]     ycc_o
);
   import ovl_mix_pkg::*;

   localparam int SHIFT = PIX_W - BASE_W;

   logic [NCOMP-1:0][BASE_W-1:0] base;

   assign base = pal_base(code_i);

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      assign ycc_o[k] = PIX_W'(base[k]) << SHIFT;
   end

endmodule

// File: rtl/ovl_blend.sv
module ovl_blend #(
   parameter int PIX_W = 8
) (
   input  logic [PIX_W-1:0]                 a_i,
   input  logic [PIX_W-1:0]                 b_i,
   input  logic [ovl_mix_pkg::WGT_W-1:0]    w_i,
   output logic [PIX_W-1:0]                 y_o
);
   import ovl_mix_pkg::*;

   localparam int SUM_W = PIX_W + WGT_W;

   logic [WGT_W-1:0] w_inv;
   logic [SUM_W-1:0] sum;

   assign w_inv = 4'd8 - w_i;
   assign sum   = ({{WGT_W{1'b0}}, a_i} * SUM_W'(w_i))
                + ({{WGT_W{1'b0}}, b_i} * SUM_W'(w_inv))
                + SUM_W'(4);
   assign y_o   = PIX_W'(sum >> 3);

endmodule

// File: rtl/ovl_mix_ctrl.sv
module ovl_mix_ctrl (
   input  logic [1:0]                       mode_i,
   input  logic [ovl_mix_pkg::SEL_W-1:0]    prev_sel_i,
   input  logic [ovl_mix_pkg::SEL_W-1:0]    cur_sel_i,
   input  logic [ovl_mix_pkg::SEL_W-1:0]    next_sel_i,
   input  logic [ovl_mix_pkg::LVL_W-1:0]    lvl_i,
   output logic [ovl_mix_pkg::SEL_W-1:0]    a_code_o,
   output logic [ovl_mix_pkg::SEL_W-1:0]    b_code_o,
   output logic [ovl_mix_pkg::WGT_W-1:0]    w_o
);
   import ovl_mix_pkg::*;

   // a code of 0 stands for the held pixel itself
   mix_mode_e mode;
   assign mode = mix_mode_e'(mode_i);

   always_comb begin
      a_code_o = cur_sel_i;
      b_code_o = '0;
      w_o      = 4'd8;
      unique case (mode)
         MIX_OFF: begin
            a_code_o = '0;
         end
         MIX_EXT: begin
            if (cur_sel_i != '0) w_o = ext_weight(lvl_i);
         end
         MIX_HARD: begin
            w_o = 4'd8;
         end
         MIX_FADE: begin
            if (next_sel_i != cur_sel_i) begin
               a_code_o = next_sel_i;
               b_code_o = cur_sel_i;
               w_o      = 4'd1;
            end else if (prev_sel_i != cur_sel_i) begin
               a_code_o = cur_sel_i;
               b_code_o = prev_sel_i;
               w_o      = 4'd7;
            end
         end
         default: a_code_o = '0;
      endcase
   end

endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer #(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             in_valid_i,
   input  logic [PIX_W-1:0] pix_y_i,
   input  logic [PIX_W-1:0] pix_cb_i,
   input  logic [PIX_W-1:0] pix_cr_i,
   input  logic [2:0]       ovl_sel_i,
   input  logic [1:0]       mix_lvl_i,
   output logic             out_valid_o,
   output logic [PIX_W-1:0] out_y_o,
   output logic [PIX_W-1:0] out_cb_o,
   output logic [PIX_W-1:0] out_cr_o
);
   import ovl_mix_pkg::*;

   if (PIX_W < BASE_W || PIX_W > 16) begin : g_bad_width
      $error("ovl_mixer: PIX_W must lie in 8..16");
   end

   logic                          h_valid;
   logic [NCOMP-1:0][PIX_W-1:0]   h_pix;
   logic [SEL_W-1:0]              h_sel;
   logic [SEL_W-1:0]              p_sel;
   logic [LVL_W-1:0]              h_lvl;

   logic [SEL_W-1:0]              a_code, b_code;
   logic [WGT_W-1:0]              wgt;
   logic [NCOMP-1:0][PIX_W-1:0]   pal_a, pal_b, src_a, src_b, mixed;
   logic [NCOMP-1:0][PIX_W-1:0]   in_pix;

   assign in_pix = {pix_cr_i, pix_cb_i, pix_y_i};

   ovl_mix_ctrl ctrl_i (
      .mode_i     (mode_i),
      .prev_sel_i (p_sel),
      .cur_sel_i  (h_sel),
      .next_sel_i (ovl_sel_i),
      .lvl_i      (h_lvl),
      .a_code_o   (a_code),
      .b_code_o   (b_code),
      .w_o        (wgt)
   );

   ovl_palette #(.PIX_W(PIX_W)) pal_a_i (.code_i(a_code), .ycc_o(pal_a));
   ovl_palette #(.PIX_W(PIX_W)) pal_b_i (.code_i(b_code), .ycc_o(pal_b));

   assign src_a = (a_code == '0) ? h_pix : pal_a;
   assign src_b = (b_code == '0) ? h_pix : pal_b;

   for (genvar k = 0; k < NCOMP; k++) begin : g_blend
      ovl_blend #(.PIX_W(PIX_W)) blend_i (
         .a_i (src_a[k]),
         .b_i (src_b[k]),
         .w_i (wgt),
         .y_o (mixed[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_valid     <= 1'b0;
         h_pix       <= '0;
         h_sel       <= '0;
         h_lvl       <= '0;
         p_sel       <= '0;
         out_valid_o <= 1'b0;
         out_y_o     <= '0;
         out_cb_o    <= '0;
         out_cr_o    <= '0;
      end else if (in_valid_i) begin
         out_valid_o <= h_valid;
         if (h_valid) begin
            out_y_o  <= mixed[0];
            out_cb_o <= mixed[1];
            out_cr_o <= mixed[2];
            p_sel    <= h_sel;
         end
         h_valid <= 1'b1;
         h_pix   <= in_pix;
         h_sel   <= ovl_sel_i;
         h_lvl   <= mix_lvl_i;
      end else begin
         out_valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic             in_valid_i,
   input logic [PIX_W-1:0] pix_y_i,
   input logic [PIX_W-1:0] pix_cb_i,
   input logic [PIX_W-1:0] pix_cr_i,
   input logic [2:0]       ovl_sel_i,
   input logic [1:0]       mix_lvl_i,
   input logic             out_valid_o,
   input logic [PIX_W-1:0] out_y_o,
   input logic [PIX_W-1:0] out_cb_o,
   input logic [PIX_W-1:0] out_cr_o
);
   logic [3*PIX_W-1:0] sh1_pix, sh2_pix, out_pix;
   logic [2:0]         sh1_sel, sh2_sel, sh3_sel;
   logic [1:0]         sh1_lvl, sh2_lvl;

   assign out_pix = {out_cr_o, out_cb_o, out_y_o};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh1_pix <= '0; sh2_pix <= '0;
         sh1_sel <= '0; sh2_sel <= '0; sh3_sel <= '0;
         sh1_lvl <= '0; sh2_lvl <= '0;
      end else if (in_valid_i) begin
         sh1_pix <= {pix_cr_i, pix_cb_i, pix_y_i};
         sh2_pix <= sh1_pix;
         sh1_sel <= ovl_sel_i;
         sh2_sel <= sh1_sel;
         sh3_sel <= sh2_sel;
         sh1_lvl <= mix_lvl_i;
         sh2_lvl <= sh1_lvl;
      end
   end

   // R2
   idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> !out_valid_o);

   // R2
   out_after_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $past(in_valid_i));

   // R3
   off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && mode_i == 2'b00) |-> out_pix == sh2_pix);

   // R4
   ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && mode_i == 2'b01 && (sh2_sel == 3'd0 || sh2_lvl == 2'd0))
      |-> out_pix == sh2_pix);

   // R4
   hard_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && mode_i == 2'b11 && sh2_sel == 3'd0) |-> out_pix == sh2_pix);

   // R11
   fade_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && mode_i == 2'b10 && sh1_sel == 3'd0 && sh2_sel == 3'd0 && sh3_sel == 3'd0)
      |-> out_pix == sh2_pix);

endmodule

bind ovl_mixer ovl_mixer_chk #(.PIX_W(PIX_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i      (mode_i),
   .in_valid_i  (in_valid_i),
   .pix_y_i     (pix_y_i),
   .pix_cb_i    (pix_cb_i),
   .pix_cr_i    (pix_cr_i),
   .ovl_sel_i   (ovl_sel_i),
   .mix_lvl_i   (mix_lvl_i),
   .out_valid_o (out_valid_o),
   .out_y_o     (out_y_o),
   .out_cb_o    (out_cb_o),
   .out_cr_o    (out_cr_o)
);

// File: tb/ovl_mixer_tb.sv
module ovl_mixer_tb_top;

   localparam int CLK_P = 10;
   localparam int MAXN  = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       in_valid = 1'b0;
   logic [7:0] py = '0, pcb = '0, pcr = '0;
   logic [2:0] sel = '0;
   logic [1:0] lvl = '0;
   logic       out_valid;
   logic [7:0] oy, ocb, ocr;

   int checks = 0;
   int errors = 0;

   logic [2:0]  s_sel [MAXN];
   logic [1:0]  s_lvl [MAXN];
   logic [23:0] s_pix [MAXN];
   int          s_gap [MAXN];
   int          n_pix = 0;
   int          rd = 0;
   bit          mon_on = 0;
   string       tag = "";

   always #(CLK_P/2) clk = ~clk;

   ovl_mixer #(.PIX_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_valid_i(in_valid),
      .pix_y_i(py), .pix_cb_i(pcb), .pix_cr_i(pcr),
      .ovl_sel_i(sel), .mix_lvl_i(lvl),
      .out_valid_o(out_valid), .out_y_o(oy), .out_cb_o(ocb), .out_cr_o(ocr)
   );

   // palette as listed in R5, packed {Cr,Cb,Y}
   function automatic logic [23:0] pal(input logic [2:0] c);
      case (c)
         3'd1: return {8'd128, 8'd128, 8'd180};
         3'd2: return {8'd142, 8'd44,  8'd162};
         3'd3: return {8'd44,  8'd156, 8'd131};
         3'd4: return {8'd58,  8'd72,  8'd112};
         3'd5: return {8'd198, 8'd184, 8'd84};
         3'd6: return {8'd212, 8'd100, 8'd65};
         3'd7: return {8'd114, 8'd212, 8'd35};
         default: return 24'd0;
      endcase
   endfunction

   function automatic logic [23:0] mixw(input logic [23:0] o, input logic [23:0] p, input int w);
      logic [23:0] r;
      for (int k = 0; k < 3; k++) begin
         int v;
         v = (int'(o[8*k +: 8]) * w + int'(p[8*k +: 8]) * (8 - w) + 4) / 8;
         r[8*k +: 8] = v[7:0];
      end
      return r;
   endfunction

   function automatic logic [23:0] expect_at(input int i);
      logic [2:0] c, pv, nx;
      logic [23:0] px;
      int w;
      c  = s_sel[i];
      px = s_pix[i];
      pv = (i == 0) ? 3'd0 : s_sel[i-1];
      nx = s_sel[i+1];
      case (mode)
         2'b00: return px;
         2'b11: return (c == 0) ? px : pal(c);
         2'b01: begin
            if (c == 0) return px;
            w = (s_lvl[i] == 0) ? 0 : (s_lvl[i] == 1) ? 1 : (s_lvl[i] == 2) ? 7 : 8;
            return mixw(pal(c), px, w);
         end
         default: begin
            if (nx != c) begin
               if (c == 0)       return mixw(pal(nx), px, 1);
               else if (nx == 0) return mixw(pal(c), px, 7);
               else              return mixw(pal(nx), pal(c), 1);
            end else if (pv != c) begin
               if (pv == 0)      return mixw(pal(c), px, 7);
               else if (c == 0)  return mixw(pal(pv), px, 1);
               else              return mixw(pal(c), pal(pv), 7);
            end
            return (c == 0) ? px : pal(c);
         end
      endcase
   endfunction

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && out_valid) begin
         if (rd >= n_pix - 1) begin
            check({tag, " R2 extra output"}, {ocr, ocb, oy}, 24'hxxxxxx);
         end else begin
            check(tag, {ocr, ocb, oy}, expect_at(rd));
         end
         rd++;
      end
   end

   task automatic do_reset(input logic [1:0] m);
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; mode = m;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load(input int i, input logic [2:0] s, input logic [1:0] l, input int gap);
      s_sel[i] = s;
      s_lvl[i] = l;
      s_pix[i] = {8'(40 + 11*i), 8'(200 - 7*i), 8'(30 + 13*i)};
      s_gap[i] = gap;
   endtask

   // stream n pixels; the last one only supplies lookahead
   task automatic run(input string t, input int n);
      tag = t; n_pix = n; rd = 0; mon_on = 1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         {pcr, pcb, py} = s_pix[i];
         sel = s_sel[i];
         lvl = s_lvl[i];
         for (int g = 0; g < s_gap[i]; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            sel = 3'd0;
            lvl = 2'd3;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check({t, " R2 output count"}, 24'(rd), 24'(n - 1));
      mon_on = 0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {out_valid, ocr, ocb, oy} , 25'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {out_valid, ocr, ocb, oy}, 25'd0);
      // a single pixel followed by idle: nothing may come out (R2)
      in_valid = 1'b1; sel = 3'd2;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check("R2 no output with one held pixel", 24'(out_valid), 24'd0);
      end
   endtask

   task automatic t_off;
      do_reset(2'b00);
      for (int i = 0; i < 10; i++) load(i, 3'(i % 8), 2'(i % 4), 0);
      run("R3 off mode", 10);
   endtask

   task automatic t_ext;
      do_reset(2'b01);
      for (int i = 0; i < 16; i++) load(i, (i < 4) ? 3'd0 : 3'(1 + (i % 7)), 2'(i % 4), 0);
      run("R4/R5/R6 external", 16);
   endtask

   task automatic t_hard;
      do_reset(2'b11);
      for (int i = 0; i < 16; i++) load(i, 3'(i % 8), 2'(3 - (i % 4)), 0);
      run("R4/R5/R7 hard switch", 16);
   endtask

   task automatic t_fade_in_out;
      do_reset(2'b10);
      for (int i = 0; i < 14; i++) load(i, (i >= 4 && i < 9) ? 3'd5 : 3'd0, 2'd0, 0);
      run("R8/R9/R11 fade in and out", 14);
   endtask

   task automatic t_fade_swap;
      do_reset(2'b10);
      for (int i = 0; i < 14; i++) load(i, (i < 5) ? 3'd2 : (i < 10) ? 3'd6 : 3'd7, 2'd1, 0);
      run("R10/R11 colour to colour", 14);
   endtask

   task automatic t_fade_short;
      do_reset(2'b10);
      for (int i = 0; i < 12; i++) load(i, (i == 3) ? 3'd3 : (i == 7 || i == 8) ? 3'd4 : 3'd0, 2'd0, 0);
      run("R12 short runs", 12);
   endtask

   task automatic t_fade_gaps;
      do_reset(2'b10);
      for (int i = 0; i < 12; i++) load(i, (i >= 3 && i < 7) ? 3'd1 : 3'd0, 2'd2, (i % 3 == 1) ? 2 : 0);
      run("R2/R8/R9 idle gaps", 12);
   endtask

   initial begin
      t_reset();
      t_off();
      t_ext();
      t_hard();
      t_fade_in_out();
      t_fade_swap();
      t_fade_short();
      t_fade_gaps();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule